// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This unit divides a 64-bit dividend by a 32-bit divisor and hands back a 32-bit quotient for a 32-bit integer datapath. The dividend is built from two words: the upper word comes from an auxiliary high-word register, and the lower word is the first operand. The divisor is the second operand. The divide runs as unsigned or signed, chosen at the start pulse. Signed division rounds toward zero, and the remainder is dropped.

The quotient does not wrap. When it does not fit in 32 bits, it is clamped to a fixed extreme value and the overflow flag is raised. A zero divisor raises a one-cycle trap strobe and leaves all results untouched. A signed dividend equal to the most negative 64-bit value has its own clamping rule. If the set-flags select is high, the unit updates N, Z, V and C, and C is always written as zero. A 64-bit view of the quotient is provided, zero-extended for unsigned divides and sign-extended for signed divides.

The core is a restoring shift-subtract loop that works on magnitudes and produces one quotient bit per clock. A divide therefore takes a fixed number of cycles, and busy stays high for that whole time.

Top module: `satdiv`

## Requirements
- R1: In unsigned mode, the dividend is {yhi_i, lo_i} and the divisor is dvs_i. If the true quotient fits in 32 bits, quo_o takes that quotient and V is 0.
- R2: In unsigned mode, a true quotient above 0xFFFFFFFF gives quo_o = 0xFFFFFFFF with V = 1.
- R3: In signed mode, both words are two's-complement values and the quotient is truncated toward zero. If that quotient lies within the signed 32-bit range, it is returned with V = 0. This includes a negative quotient of exactly 0x80000000.
- R4: In signed mode, a quotient above 0x7FFFFFFF gives 0x7FFFFFFF, and a quotient below -0x80000000 gives 0x80000000. V = 1 in both cases.
- R5: In signed mode, a dividend of 0x8000000000000000 always overflows for any nonzero divisor. The result is 0x7FFFFFFF when the divisor's bit 31 is 1 and 0x80000000 otherwise, with V = 1.
- R6: cc_o is {N, Z, V, C} in bits 3 down to 0. When setcc_i was high at the start, cc_o is written on completion with N = quo bit 31, Z = (quo == 0), V as above and C = 0. When setcc_i was low, cc_o keeps its value.
- R7: A start with dvs_i == 0 raises trap_o for exactly the one cycle after the start edge. busy_o and done_o stay low, and quo_o, quo64_o and cc_o keep their values.
- R8: An accepted start with a nonzero divisor sets busy_o from the next cycle. Sixty-five clock edges after the start edge, busy_o falls, done_o is high for exactly one cycle, and the new results appear in that same cycle.
- R9: A start pulse while busy_o is high is ignored, and the operation in flight completes with its own operands.
- R10: quo64_o is quo_o zero-extended after an unsigned divide and sign-extended after a signed divide.
- R11: After a synchronous reset, quo_o, quo64_o, cc_o, trap_o, done_o and busy_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| sgn_i | input | 1 | 1 selects a signed divide, 0 an unsigned divide |
| setcc_i | input | 1 | 1 updates the condition flags on completion |
| yhi_i | input | 32 | Upper dividend word, from the high-word register |
| lo_i | input | 32 | Lower dividend word |
| dvs_i | input | 32 | Divisor |
| quo_o | output | 32 | Quotient after saturation |
| quo64_o | output | 64 | Quotient extended to 64 bits according to the mode |
| cc_o | output | 4 | Condition flags {N, Z, V, C} |
| trap_o | output | 1 | Divide-by-zero strobe |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Divide in progress |

## Verification
Each result has a fixed due cycle counted from the edge that samples start_i:
- trap_o is due one cycle later.
- busy_o rises one cycle later.
- done_o, the new quo_o/quo64_o and the flags are due together, 65 edges after the start edge.

The bench's reference model counts the same 65 edges with a plain integer countdown and computes each expected quotient with 64-bit integer arithmetic. Every output is compared against the model on each falling edge. An early or late done, a trap that lasts two cycles, or a flag update outside the completion cycle all show up as a mismatch in the exact cycle where it occurs.

// File: rtl/satdiv_pkg.sv
package satdiv_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned DVD_W  = 2 * WORD_W;
    localparam int unsigned CNT_W  = $clog2(DVD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DVD_W-1:0]  dword_t;

    localparam word_t UMAX = {WORD_W{1'b1}};
    localparam word_t SMAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam word_t SMIN = {1'b1, {(WORD_W-1){1'b0}}};
    localparam dword_t DMIN = {1'b1, {(DVD_W-1){1'b0}}};

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_t;

    typedef struct packed {
        logic sgn;
        logic setcc;
        logic neg_q;
        logic min_dvd;
        logic dvs_neg;
    } job_t;

    typedef struct packed {
        word_t res;
        logic  ovf;
    } outcome_t;

    function automatic dword_t mag64(input dword_t x, input logic s);
        dword_t r;
        r = (s && x[DVD_W-1]) ? (~x + 1'b1) : x;
        return r;
    endfunction

    function automatic word_t mag32(input word_t x, input logic s);
        word_t r;
        r = (s && x[WORD_W-1]) ? (~x + 1'b1) : x;
        return r;
    endfunction
endpackage

// File: rtl/satdiv_prep.sv
module satdiv_prep
    import satdiv_pkg::*;
(
    input  word_t  hi_i,
    input  word_t  lo_i,
    input  word_t  dvs_i,
    input  logic   sgn_i,
    output dword_t dvd_mag_o,
    output word_t  dvs_mag_o,
    output logic   dvs_zero_o,
    output logic   neg_q_o,
    output logic   min_dvd_o,
    output logic   dvs_neg_o
);
    dword_t dvd;

    always_comb begin
        dvd        = {hi_i, lo_i};
        dvd_mag_o  = mag64(dvd, sgn_i);
        dvs_mag_o  = mag32(dvs_i, sgn_i);
        dvs_zero_o = (dvs_i == '0);
        dvs_neg_o  = sgn_i & dvs_i[WORD_W-1];
        neg_q_o    = sgn_i & (dvd[DVD_W-1] ^ dvs_i[WORD_W-1]);
        min_dvd_o  = sgn_i & (dvd == DMIN);
    end
endmodule

// File: rtl/satdiv_core.sv
module satdiv_core
    import satdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  dword_t dvd_i,
    input  word_t  dvs_i,
    output logic   run_o,
    output logic   fin_o,
    output dword_t qmag_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    word_t            acc_q;
    dword_t           sh_q;
    word_t            dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             fin_q;

    logic [WORD_W:0] trial;
    logic [WORD_W:0] diff;
    logic            take;
    word_t           acc_nx;

    always_comb begin
        trial  = {acc_q, sh_q[DVD_W-1]};
        diff   = trial - {1'b0, dvs_q};
        take   = ~diff[WORD_W];
        acc_nx = take ? diff[WORD_W-1:0] : trial[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sh_q  <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i && !run_q) begin
                acc_q <= '0;
                sh_q  <= dvd_i;
                dvs_q <= dvs_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= acc_nx;
                sh_q  <= {sh_q[DVD_W-2:0], take};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign run_o  = run_q;
    assign fin_o  = fin_q;
    assign qmag_o = sh_q;

    // R8
    fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q);

    // R8
    fin_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q == LAST) |=> (fin_q && !run_q));
endmodule

// File: rtl/satdiv_fin.sv
module satdiv_fin
    import satdiv_pkg::*;
(
    input  dword_t   qmag_i,
    input  job_t     job_i,
    output outcome_t out_o
);
    logic  hi_nz;
    word_t low;

    always_comb begin
        hi_nz = |qmag_i[DVD_W-1:WORD_W];
        low   = qmag_i[WORD_W-1:0];
        if (!job_i.sgn) begin
            out_o.ovf = hi_nz;
            out_o.res = hi_nz ? UMAX : low;
        end else if (job_i.min_dvd) begin
            out_o.ovf = 1'b1;
            out_o.res = job_i.dvs_neg ? SMAX : SMIN;
        end else if (job_i.neg_q) begin
            out_o.ovf = hi_nz || (low > SMIN);
            out_o.res = out_o.ovf ? SMIN : (~low + 1'b1);
        end else begin
            out_o.ovf = hi_nz || low[WORD_W-1];
            out_o.res = out_o.ovf ? SMAX : low;
        end
    end
endmodule

// File: rtl/satdiv.sv
module satdiv
    import satdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        sgn_i,
    input  logic        setcc_i,
    input  logic [31:0] yhi_i,
    input  logic [31:0] lo_i,
    input  logic [31:0] dvs_i,
    output logic [31:0] quo_o,
    output logic [63:0] quo64_o,
    output logic [3:0]  cc_o,
    output logic        trap_o,
    output logic        done_o,
    output logic        busy_o
);
    dword_t   dvd_mag;
    word_t    dvs_mag;
    logic     dvs_zero, neg_q, min_dvd, dvs_neg;
    logic     accept, load;
    logic     core_run, core_fin;
    dword_t   qmag;
    outcome_t outc;

    logic  pend_q;
    job_t  job_q;
    word_t quo_q;
    logic  view_sgn_q;
    ccf_t  cc_q;
    logic  trap_q;
    logic  done_q;

    satdiv_prep u_prep (
        .hi_i       (yhi_i),
        .lo_i       (lo_i),
        .dvs_i      (dvs_i),
        .sgn_i      (sgn_i),
        .dvd_mag_o  (dvd_mag),
        .dvs_mag_o  (dvs_mag),
        .dvs_zero_o (dvs_zero),
        .neg_q_o    (neg_q),
        .min_dvd_o  (min_dvd),
        .dvs_neg_o  (dvs_neg)
    );

    assign accept = start_i && !pend_q;
    assign load   = accept && !dvs_zero;

    satdiv_core u_core (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .dvd_i  (dvd_mag),
        .dvs_i  (dvs_mag),
        .run_o  (core_run),
        .fin_o  (core_fin),
        .qmag_o (qmag)
    );

    satdiv_fin u_fin (
        .qmag_i (qmag),
        .job_i  (job_q),
        .out_o  (outc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            job_q      <= '0;
            quo_q      <= '0;
            view_sgn_q <= 1'b0;
            cc_q       <= '0;
            trap_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            trap_q <= accept && dvs_zero;
            done_q <= 1'b0;
            if (load) begin
                pend_q        <= 1'b1;
                job_q.sgn     <= sgn_i;
                job_q.setcc   <= setcc_i;
                job_q.neg_q   <= neg_q;
                job_q.min_dvd <= min_dvd;
                job_q.dvs_neg <= dvs_neg;
            end
            if (core_fin) begin
                pend_q     <= 1'b0;
                done_q     <= 1'b1;
                quo_q      <= outc.res;
                view_sgn_q <= job_q.sgn;
                if (job_q.setcc) begin
                    cc_q.n <= outc.res[WORD_W-1];
                    cc_q.z <= (outc.res == '0);
                    cc_q.v <= outc.ovf;
                    cc_q.c <= 1'b0;
                end
            end
        end
    end

    assign quo_o   = quo_q;
    assign quo64_o = view_sgn_q ? {{WORD_W{quo_q[WORD_W-1]}}, quo_q}
                                : {{WORD_W{1'b0}}, quo_q};
    assign cc_o    = cc_q;
    assign trap_o  = trap_q;
    assign done_o  = done_q;
    assign busy_o  = pend_q;

    // R7
    trap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |=> !trap_o);

    // R7
    trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ($stable(quo_o) && $stable(cc_o) && !busy_o));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R6
    flags_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cc_o != $past(cc_o)) |-> done_o);

    // R9
    core_idle_chk: assert property (@(posedge clk) disable iff (rst)
        core_run |-> busy_o);
endmodule

// File: tb/satdiv_bench.sv
`timescale 1ns/1ps
module satdiv_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, sgn = 1'b0, setcc = 1'b0;
    logic [31:0] yhi = '0, lo = '0, dvs = '0;
    logic [31:0] quo_o;
    logic [63:0] quo64_o;
    logic [3:0]  cc_o;
    logic        trap_o, done_o, busy_o;

    int    n_chk = 0, n_bad = 0;
    bit    chk_on = 0, ended = 0;
    string cur_tag = "R1";

    // reference model state
    bit          m_busy = 0, m_done = 0, m_trap = 0, m_wide = 0;
    int          m_cnt = 0;
    logic [31:0] m_quo = '0;
    logic [3:0]  m_cc = '0;
    logic [31:0] p_res;
    bit          p_v, p_sgn, p_setcc;

    always #2 clk = ~clk;

    satdiv u_satdiv (
        .clk(clk), .rst(rst), .start_i(start), .sgn_i(sgn), .setcc_i(setcc),
        .yhi_i(yhi), .lo_i(lo), .dvs_i(dvs),
        .quo_o(quo_o), .quo64_o(quo64_o), .cc_o(cc_o),
        .trap_o(trap_o), .done_o(done_o), .busy_o(busy_o)
    );

    function automatic void ref_div(input logic [31:0] h, l, d, input bit s,
                                    output logic [31:0] r, output bit v);
        logic [63:0] a;
        longint unsigned uq;
        longint sa, sq;
        a = {h, l};
        if (!s) begin
            uq = a / {32'b0, d};
            v  = (uq > 64'h0000_0000_FFFF_FFFF);
            r  = v ? 32'hFFFF_FFFF : uq[31:0];
        end else if (a == 64'h8000_0000_0000_0000) begin
            v = 1;
            r = d[31] ? 32'h7FFF_FFFF : 32'h8000_0000;
        end else begin
            sa = $signed(a);
            sq = sa / longint'($signed(d));
            if (sq > 64'sd2147483647) begin
                v = 1; r = 32'h7FFF_FFFF;
            end else if (sq < -64'sd2147483648) begin
                v = 1; r = 32'h8000_0000;
            end else begin
                v = 0; r = sq[31:0];
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_trap = 0; m_wide = 0;
            m_cnt = 0; m_quo = '0; m_cc = '0;
        end else begin
            m_done = 0;
            m_trap = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_quo  = p_res;
                    m_wide = p_sgn;
                    if (p_setcc)
                        m_cc = {p_res[31], p_res == 32'h0, p_v, 1'b0};
                end
            end else if (start) begin
                if (dvs == 32'h0) begin
                    m_trap = 1;
                end else begin
                    m_busy  = 1;
                    m_cnt   = 65;
                    ref_div(yhi, lo, dvs, sgn, p_res, p_v);
                    p_sgn   = sgn;
                    p_setcc = setcc;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !ended) begin
            chk("R8", "busy", {63'b0, busy_o}, {63'b0, m_busy});
            chk("R8", "done", {63'b0, done_o}, {63'b0, m_done});
            chk("R7", "trap", {63'b0, trap_o}, {63'b0, m_trap});
            chk(cur_tag, "quotient", {32'b0, quo_o}, {32'b0, m_quo});
            chk("R6", "flags", {60'b0, cc_o}, {60'b0, m_cc});
            chk("R10", "wide quotient", quo64_o,
                m_wide ? {{32{m_quo[31]}}, m_quo} : {32'b0, m_quo});
        end
    end

    task automatic op(input logic [31:0] h, l, d, input bit s, c, input string tag);
        @(negedge clk);
        yhi = h; lo = l; dvs = d; sgn = s; setcc = c; start = 1; cur_tag = tag;
        @(negedge clk);
        start = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "quotient", {32'b0, quo_o}, 64'h0);
        chk("R11", "wide quotient", quo64_o, 64'h0);
        chk("R11", "flags", {60'b0, cc_o}, 64'h0);
        chk("R11", "status", {61'b0, trap_o, done_o, busy_o}, 64'h0);
        rst = 0;
        chk_on = 1;

        // R1: unsigned, in range
        op(32'h0, 32'd100, 32'd7, 0, 1, "R1");
        op(32'h1, 32'h0, 32'd2, 0, 1, "R1");
        op(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R1");
        // R2: unsigned saturation
        op(32'h1, 32'h0, 32'd1, 0, 1, "R2");
        op(32'h8000_0000, 32'h0, 32'd3, 0, 1, "R2");
        // R3: signed, truncation toward zero
        op(32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 1, 1, "R3");
        op(32'h0, 32'd100, 32'hFFFF_FFF9, 1, 1, "R3");
        op(32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 1, 1, "R3");
        op(32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1, 1, "R3");
        // R4: signed saturation both ways
        op(32'h0, 32'h8000_0000, 32'd1, 1, 1, "R4");
        op(32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 1, 1, "R4");
        op(32'h4000_0000, 32'h0, 32'hFFFF_FFFE, 1, 1, "R4");
        // R5: most negative dividend
        op(32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1, 1, "R5");
        op(32'h8000_0000, 32'h0, 32'd7, 1, 1, "R5");
        op(32'h8000_0000, 32'h0, 32'h8000_0000, 1, 1, "R5");
        op(32'h8000_0000, 32'h0, 32'h7FFF_FFFF, 1, 1, "R5");
        // R6: zero result sets Z, then flags held with setcc low
        op(32'h0, 32'd5, 32'd9, 0, 1, "R6");
        op(32'h0, 32'h8000_0000, 32'd1, 1, 0, "R6");
        // R7: zero divisor traps, results kept
        op(32'h0, 32'd50, 32'h0, 0, 1, "R7");
        op(32'hFFFF_FFFF, 32'd1, 32'h0, 1, 1, "R7");

        // R9: start while busy is ignored
        @(negedge clk);
        yhi = 32'h0; lo = 32'd1000; dvs = 32'd10; sgn = 0; setcc = 1; start = 1;
        cur_tag = "R9";
        @(negedge clk);
        start = 0;
        repeat (10) @(negedge clk);
        yhi = 32'h0; lo = 32'd77; dvs = 32'h0; start = 1;
        @(negedge clk);
        lo = 32'd9999; dvs = 32'd3;
        @(negedge clk);
        start = 0;
        while (m_busy) @(negedge clk);
        @(negedge clk);

        // R1 R3 R10: mixed operands
        for (int i = 0; i < 24; i++) begin
            logic [31:0] h, l, d;
            bit s;
            s = i[0];
            h = (i % 3 == 0) ? $urandom : ($urandom & 32'h0000_00FF);
            if (s && i[1]) h = ~h;
            l = $urandom;
            d = $urandom;
            if (i % 4 == 3) d = d & 32'h0000_FFFF;
            if (d == 0) d = 32'd5;
            op(h, l, d, s, 1, s ? "R3" : "R1");
        end

        finish_run();
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end
endmodule